// File: doc/BRIEF.md
# Banked Scratch Memory Conflict Arbiter

This block serves one warp-wide access to an on-chip scratch memory that is split into independent word-wide banks. A request carries up to 32 lane addresses, a per-lane enable mask, a direction flag and per-lane write data. The arbiter works out which lanes land in which bank. It then issues the access as a series of passes. In each pass every bank handles one word, and every pending lane that wants that word is served in the same pass. Several readers of one word therefore get a single broadcast, while lanes that want different words of the same bank are spread over later passes.

The request side and the response side are both valid/ready streams. A request is taken only while the block is idle. The response holds the gathered read data and the number of passes the access took. It stays on the outputs until the consumer takes it, and only then does the block accept the next request. The bank storage is a plain array of words per bank. Column padding that avoids conflicts is done by software through the choice of addresses.

Top module: `smem_conflict_arbiter`

## Requirements
- R1: `req_ready` is 1 only while the block is idle with no response outstanding. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from the following cycle until the response has been taken.
- R2: A lane's bank is its word address modulo `NBANKS` (the low `log2(NBANKS)` address bits). Its row within the bank is the remaining upper bits. `NBANKS` is 16 or 32.
- R3: In each pass, each bank picks the word of its lowest-numbered pending lane. Every pending lane that targets that same word is served in that pass, and each bank touches at most one word per pass.
- R4: `rsp_passes` equals the largest number of distinct words that active lanes request from any single bank. It is 0 when the mask is empty.
- R5: After the acceptance edge, `rsp_valid` rises after max(P,1) further clock edges, where P is the pass count.
- R6: On a read, every active lane receives the word stored at its address, including lanes that share a word and are served by broadcast.
- R7: When several active lanes write the same word, the value from the highest-numbered of them is stored. Lanes that write different words all take effect.
- R8: Inactive lanes neither read nor write memory. Their `rsp_rdata` slice is zero, and after a write every `rsp_rdata` slice is zero.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its data hold steady. After the edge where both are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R10: Reset (active-low `rst_n`, asynchronous) returns the block to idle, with `req_ready` 1 and `rsp_valid` 0, even while an access is in progress.
- R11: A column walk with a stride of `NBANKS`+1 words (one padding word per row) finishes in one pass. A stride of exactly `NBANKS` over 32 lanes needs 32 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mask | input | LANES | Per-lane active enable |
| req_addr | input | LANES*ADDR_W | Word address of lane i at bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Store data of lane i at bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | 1 | Access complete, response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | LANES*DATA_W | Load data of lane i at bits [i*DATA_W +: DATA_W] |
| rsp_passes | output | $clog2(LANES+1) | Number of passes the access used |

## Verification
Conflict splitting and same-word merging can fall in the same pass. A bank can serve a broadcast group of lanes in one pass while other lanes of that bank, which want different words, wait for later passes. The bench provokes this with an address pattern that gives four words in one bank, each shared by eight lanes. Run as a load, it is judged by a pass count of four and by every lane returning its own word. Run as a store, it is judged by a later load showing that lane 28 to 31 data won each word. A pass count that came out as eight or thirty-two, or data from the wrong lane, would show that merging and splitting interfered.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DONE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/smem_pass_picker.sv
module smem_pass_picker #(
  parameter int LANES  = 32,
  parameter int NBANKS = 32,
  parameter int ADDR_W = 10
) (
  input  logic [LANES-1:0]                                  pend,
  input  logic [LANES*ADDR_W-1:0]                           lane_addr,
  output logic [NBANKS-1:0]                                 bank_hit,
  output logic [NBANKS*(ADDR_W-$clog2(NBANKS))-1:0]         bank_row,
  output logic [NBANKS*$clog2(LANES)-1:0]                   bank_wlane,
  output logic [LANES-1:0]                                  served
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int LANE_W = $clog2(LANES);

  logic [BANK_W-1:0] l_bank [LANES];
  logic [ROW_W-1:0]  l_row  [LANES];
  logic [ROW_W-1:0]  b_row  [NBANKS];
  logic [LANE_W-1:0] b_wl   [NBANKS];

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign l_bank[l] = lane_addr[l*ADDR_W +: BANK_W];
    assign l_row[l]  = lane_addr[l*ADDR_W + BANK_W +: ROW_W];
  end

  // Lowest pending lane per bank chooses the word: scan downwards, last hit wins.
  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      bank_hit[b] = 1'b0;
      b_row[b]    = '0;
    end
    for (int l = LANES-1; l >= 0; l--) begin
      if (pend[l]) begin
        bank_hit[l_bank[l]] = 1'b1;
        b_row[l_bank[l]]    = l_row[l];
      end
    end
  end

  // Every pending lane that wants its bank's chosen word goes in this pass.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pend[l] && (b_row[l_bank[l]] == l_row[l]);
    end
  end

  // Store merge: highest served lane per bank supplies the data.
  always_comb begin
    for (int b = 0; b < NBANKS; b++) b_wl[b] = '0;
    for (int l = 0; l < LANES; l++) begin
      if (served[l]) b_wl[l_bank[l]] = LANE_W'(l);
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_pack
    assign bank_row[b*ROW_W +: ROW_W]     = b_row[b];
    assign bank_wlane[b*LANE_W +: LANE_W] = b_wl[b];
  end
endmodule

// File: rtl/smem_xbar.sv
module smem_xbar #(
  parameter int LANES  = 32,
  parameter int NBANKS = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic [LANES*ADDR_W-1:0]          lane_addr,
  input  logic [LANES*DATA_W-1:0]          lane_wdata,
  input  logic [NBANKS*$clog2(LANES)-1:0]  bank_wlane,
  input  logic [NBANKS*DATA_W-1:0]         bank_rdata,
  output logic [NBANKS*DATA_W-1:0]         bank_wdata,
  output logic [LANES*DATA_W-1:0]          lane_rdata
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int LANE_W = $clog2(LANES);

  logic [DATA_W-1:0] b_rd [NBANKS];
  logic [DATA_W-1:0] l_wd [LANES];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign b_rd[b] = bank_rdata[b*DATA_W +: DATA_W];
    assign bank_wdata[b*DATA_W +: DATA_W] = l_wd[bank_wlane[b*LANE_W +: LANE_W]];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign l_wd[l] = lane_wdata[l*DATA_W +: DATA_W];
    assign lane_rdata[l*DATA_W +: DATA_W] = b_rd[lane_addr[l*ADDR_W +: BANK_W]];
  end
endmodule

// File: rtl/smem_bank_array.sv
module smem_bank_array #(
  parameter int NBANKS = 32,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic [NBANKS-1:0]          bank_we,
  input  logic [NBANKS*ROW_W-1:0]    bank_row,
  input  logic [NBANKS*DATA_W-1:0]   bank_wdata,
  output logic [NBANKS*DATA_W-1:0]   bank_rdata
);
  localparam int ROWS = 1 << ROW_W;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [ROWS];
    logic [ROW_W-1:0]  row;
    assign row = bank_row[b*ROW_W +: ROW_W];
    always_ff @(posedge clk) begin
      if (bank_we[b]) store[row] <= bank_wdata[b*DATA_W +: DATA_W];
    end
    assign bank_rdata[b*DATA_W +: DATA_W] = store[row];
  end
endmodule

// File: rtl/smem_conflict_arbiter.sv
module smem_conflict_arbiter
  import smem_arb_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int NBANKS = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [LANES-1:0]              req_mask,
  input  logic [LANES*ADDR_W-1:0]       req_addr,
  input  logic [LANES*DATA_W-1:0]       req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [LANES*DATA_W-1:0]       rsp_rdata,
  output logic [$clog2(LANES+1)-1:0]    rsp_passes
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int PASS_W = $clog2(LANES+1);

  arb_state_e              state_q;
  logic [LANES-1:0]        pend_q;
  logic [PASS_W-1:0]       passes_q;
  logic                    write_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wdata_q;
  logic [LANES*DATA_W-1:0] rdata_q;

  logic                        accept;
  logic                        pass_active;
  logic [NBANKS-1:0]           bank_hit;
  logic [NBANKS*ROW_W-1:0]     bank_row;
  logic [NBANKS*LANE_W-1:0]    bank_wlane;
  logic [LANES-1:0]            served;
  logic [LANES-1:0]            pend_next;
  logic [NBANKS-1:0]           bank_we;
  logic [NBANKS*DATA_W-1:0]    bank_wdata;
  logic [NBANKS*DATA_W-1:0]    bank_rdata;
  logic [LANES*DATA_W-1:0]     lane_rdata;

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_DONE);
  assign accept      = req_valid && req_ready;
  assign pass_active = (state_q == ST_PASS);
  assign pend_next   = pend_q & ~served;
  assign bank_we     = (pass_active && write_q) ? bank_hit : '0;
  assign rsp_rdata   = rdata_q;
  assign rsp_passes  = passes_q;

  smem_pass_picker #(.LANES(LANES), .NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_picker (
    .pend       (pend_q),
    .lane_addr  (addr_q),
    .bank_hit   (bank_hit),
    .bank_row   (bank_row),
    .bank_wlane (bank_wlane),
    .served     (served)
  );

  smem_xbar #(.LANES(LANES), .NBANKS(NBANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xbar (
    .lane_addr  (addr_q),
    .lane_wdata (wdata_q),
    .bank_wlane (bank_wlane),
    .bank_rdata (bank_rdata),
    .bank_wdata (bank_wdata),
    .lane_rdata (lane_rdata)
  );

  smem_bank_array #(.NBANKS(NBANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_banks (
    .clk        (clk),
    .bank_we    (bank_we),
    .bank_row   (bank_row),
    .bank_wdata (bank_wdata),
    .bank_rdata (bank_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      passes_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_PASS;
            pend_q   <= req_mask;
            passes_q <= '0;
          end
        end
        ST_PASS: begin
          pend_q <= pend_next;
          if (served != '0) passes_q <= passes_q + PASS_W'(1);
          if (pend_next == '0) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      rdata_q <= '0;
    end else if (pass_active && !write_q) begin
      for (int l = 0; l < LANES; l++) begin
        if (served[l]) rdata_q[l*DATA_W +: DATA_W] <= lane_rdata[l*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/smem_conflict_arbiter_chk.sv
module smem_conflict_arbiter_chk #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic [LANES*DATA_W-1:0]     rsp_rdata,
  input logic [$clog2(LANES+1)-1:0]  rsp_passes,
  input logic                        pass_active,
  input logic [LANES-1:0]            pend_q
);
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_pass_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_active && pend_q != '0) |=> ($countones(pend_q) < $past($countones(pend_q))));

  p_pass_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_passes <= LANES));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_passes)));

  p_rsp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
endmodule

bind smem_conflict_arbiter smem_conflict_arbiter_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_passes  (rsp_passes),
  .pass_active (pass_active),
  .pend_q      (pend_q)
);

// File: tb/smem_conflict_arbiter_bench.sv
`timescale 1ns/1ps
module smem_conflict_arbiter_bench;
  localparam int LANES  = 32;
  localparam int NBANKS = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << ADDR_W;

  typedef struct packed {
    logic        wr;
    logic [9:0]  base;
    logic [10:0] stride;
    logic [5:0]  modv;
    logic [31:0] mask;
    logic [5:0]  passes;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd0, 11'd1,  6'd32, 32'hFFFF_FFFF, 6'd1 },
    '{1'b0, 10'd0, 11'd32, 6'd32, 32'hFFFF_FFFF, 6'd32},
    '{1'b0, 10'd5, 11'd33, 6'd32, 32'hFFFF_FFFF, 6'd1 },
    '{1'b0, 10'd0, 11'd2,  6'd32, 32'hFFFF_FFFF, 6'd2 },
    '{1'b0, 10'd7, 11'd0,  6'd32, 32'hFFFF_FFFF, 6'd1 },
    '{1'b1, 10'd9, 11'd0,  6'd32, 32'hFFFF_FFFF, 6'd1 },
    '{1'b0, 10'd9, 11'd1,  6'd32, 32'hFFFF_FFFF, 6'd1 },
    '{1'b1, 10'd3, 11'd32, 6'd32, 32'h0000_FFFF, 6'd16},
    '{1'b0, 10'd3, 11'd32, 6'd32, 32'hFFFF_FFFF, 6'd32},
    '{1'b0, 10'd0, 11'd1,  6'd32, 32'h0000_0000, 6'd0 },
    '{1'b0, 10'd0, 11'd16, 6'd32, 32'hFFFF_FFFF, 6'd16},
    '{1'b1, 10'd1, 11'd2,  6'd32, 32'hAAAA_AAAA, 6'd2 },
    '{1'b0, 10'd4, 11'd32, 6'd4,  32'hFFFF_FFFF, 6'd4 },
    '{1'b1, 10'd4, 11'd32, 6'd4,  32'hFFFF_FFFF, 6'd4 },
    '{1'b0, 10'd4, 11'd32, 6'd4,  32'hFFFF_FFFF, 6'd4 },
    '{1'b0, 10'd0, 11'd64, 6'd32, 32'h0000_0003, 6'd2 }
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [LANES*DATA_W-1:0] rsp_rdata;
  logic [5:0] rsp_passes;

  logic [DATA_W-1:0] model [WORDS];
  logic [ADDR_W-1:0] a_l [LANES];
  int n_chk = 0;
  int n_bad = 0;
  int tag = 0;

  always #2.5 clk = ~clk;

  smem_conflict_arbiter #(.LANES(LANES), .NBANKS(NBANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
    u_smem_conflict_arbiter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .rsp_passes(rsp_passes));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] wd(input int l, input int k);
    return {8'(k) ^ 8'h5A, 8'(l), 8'(k + l), 8'hC3};
  endfunction

  // Issue one request; checks timing, pass count, data; updates the model.
  task automatic run_req(input logic wr, input logic [31:0] mask, input int exp_p);
    int cyc;
    int want;
    tag++;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*ADDR_W +: ADDR_W]  = a_l[l];
      req_wdata[l*DATA_W +: DATA_W] = wd(l, tag);
    end
    req_write = wr;
    req_mask  = mask;
    req_valid = 1'b1;
    chk("R1 idle ready", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy not ready", 64'(req_ready), 64'd0);
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    want = (exp_p > 1) ? exp_p : 1;
    chk("R5 latency", 64'(cyc), 64'(want));
    chk("R2 R4 passes", 64'(rsp_passes), 64'(exp_p));
    for (int l = 0; l < LANES; l++) begin
      if (wr || !mask[l])
        chk("R8 idle lane data", 64'(rsp_rdata[l*DATA_W +: DATA_W]), 64'd0);
      else
        chk("R6 R7 read data", 64'(rsp_rdata[l*DATA_W +: DATA_W]), 64'(model[a_l[l]]));
    end
    if (wr) begin
      for (int l = 0; l < LANES; l++) if (mask[l]) model[a_l[l]] = wd(l, tag);
    end
    if (rsp_ready) begin
      @(negedge clk);
      chk("R9 release", 64'({rsp_valid, req_ready}), 64'b01);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 reset ready", 64'(req_ready), 64'd1);
    chk("R10 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Preload the whole memory, one row of banks per request.
    for (int r = 0; r < WORDS / LANES; r++) begin
      for (int l = 0; l < LANES; l++) a_l[l] = ADDR_W'(r * LANES + l);
      run_req(1'b1, 32'hFFFF_FFFF, 1);
    end

    // Vector table: R3 R4 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      for (int l = 0; l < LANES; l++)
        a_l[l] = ADDR_W'(int'(VECS[v].base) + (l % int'(VECS[v].modv)) * int'(VECS[v].stride));
      run_req(VECS[v].wr, VECS[v].mask, int'(VECS[v].passes));
    end

    // R9: back-pressure holds the response.
    for (int l = 0; l < LANES; l++) a_l[l] = ADDR_W'(100 + 3 * l);
    rsp_ready = 1'b0;
    run_req(1'b0, 32'hF0F0_F0F0, 1);
    begin
      logic [LANES*DATA_W-1:0] held;
      held = rsp_rdata;
      repeat (3) @(negedge clk);
      chk("R9 hold valid", 64'(rsp_valid), 64'd1);
      chk("R9 hold ready low", 64'(req_ready), 64'd0);
      chk("R9 hold data", 64'(held == rsp_rdata), 64'd1);
      chk("R9 hold passes", 64'(rsp_passes), 64'd1);
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R9 after take", 64'({rsp_valid, req_ready}), 64'b01);
    end

    // R10: reset in the middle of a 32-pass access.
    for (int l = 0; l < LANES; l++) a_l[l] = ADDR_W'(32 * l);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = a_l[l];
    req_write = 1'b0;
    req_mask  = 32'hFFFF_FFFF;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 busy before reset", 64'(req_ready), 64'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid reset ready", 64'(req_ready), 64'd1);
    chk("R10 mid reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Memory survives the reset; repeat the padded column walk (R11).
    for (int l = 0; l < LANES; l++) a_l[l] = ADDR_W'(33 * l);
    run_req(1'b0, 32'hFFFF_FFFF, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule